// File: doc/BRIEF.md
# Ancillary Packet Blanking Filter

This block sits in a 10-bit digital video word stream and removes ancillary data packets by overwriting them in place with blanking values. It watches each valid word for the three-word packet flag. It reads the packet's identifier and secondary identifier, then decides whether the packet is to be erased. The stream passes through a word-counted delay line, so the decision can reach back and blank the flag and identifier words that came before it. Words that are not deleted come out exactly as they went in, in their original slots. Nothing is shifted, dropped or closed up.

A small table of identifier filters chooses the packets to erase. An entry can match on the identifier alone, or on the identifier together with the secondary identifier. If no entry is marked valid, every detected packet is erased. A global processing enable turns the whole function into a plain delay. A separate delete enable lets packets through untouched without disabling detection.

Top module: `anc_blank_filter`

## Requirements
- R1: While `proc_en` is low, every output word equals the input word it carries, and no packet is detected or blanked.
- R2: If `del_en` is low when a packet's secondary identifier word arrives, that packet leaves unchanged.
- R3: Each blanked word is replaced by 0x200 if its own `in_chroma` flag was 1, and by 0x040 if it was 0.
- R4: If no filter entry has its valid bit set, every detected packet is blanked while `proc_en` and `del_en` are high.
- R5: An entry with its SDID-check bit clear matches on the low 8 bits of the identifier word only. An entry with the bit set must also match the low 8 bits of the secondary identifier word. When any entry is valid, only packets that match at least one valid entry are blanked.
- R6: The word taken in with the k-th valid input leaves with `out_valid` high in the cycle after the (k+DEPTH)-th valid input. No word is dropped, added or reordered.
- R7: A packet is the valid-word sequence 0x000, 0x3FF, 0x3FF, identifier, secondary identifier, count word, then N user words and one checksum word, where N is the count word's low 8 bits. A blanked packet has all 7+N of its words blanked, the flag included.
- R8: Words outside blanked packets are unchanged, including words directly after a blanked packet and the words of packets that follow it back to back.
- R9: During reset and for the first DEPTH valid inputs after it, `out_valid` is 0, and `out_word` resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 10 | Input video word |
| in_valid | input | 1 | Input word strobe |
| in_chroma | input | 1 | 1 = chroma sample position, 0 = luma |
| proc_en | input | 1 | Global processing enable |
| del_en | input | 1 | Packet deletion enable |
| flt_did | input | 8*NENT | Per-entry identifier, entry e at bits [8e+7:8e] |
| flt_sdid | input | 8*NENT | Per-entry secondary identifier |
| flt_sdid_chk | input | NENT | Per-entry: also compare secondary identifier |
| flt_vld | input | NENT | Per-entry valid |
| out_word | output | 10 | Filtered video word |
| out_valid | output | 1 | Output word strobe |

## Verification
Every result is due a fixed number of valid words after the word that causes it. The k-th input word appears in the cycle after the (k+DEPTH)-th valid input, however many idle cycles lie between inputs. The bench therefore does not count clock cycles. It collects each output word in order on the falling edge and compares the k-th collected word with a model of the k-th input. It appends DEPTH filler words so that every word it wants to check comes out. The one check that depends on cycle timing is the start-up window. There, `out_valid` is sampled after each of the first DEPTH inputs and once more after input DEPTH+1.

// File: rtl/anc_pkg.sv
package anc_pkg;
  localparam int WW = 10;
  localparam logic [WW-1:0] FLAG0 = 10'h000;
  localparam logic [WW-1:0] FLAG1 = 10'h3FF;
  localparam logic [WW-1:0] BLANK_C = 10'h200;
  localparam logic [WW-1:0] BLANK_Y = 10'h040;
  localparam int HDR_BACK = 4;

  typedef enum logic [2:0] {
    PS_SEARCH, PS_DID, PS_SDID, PS_COUNT, PS_BODY
  } pstate_t;

  function automatic logic [WW-1:0] blank_of(input logic chroma);
    return chroma ? BLANK_C : BLANK_Y;
  endfunction
endpackage

// File: rtl/anc_id_match.sv
module anc_id_match #(
  parameter int NENT = 4
) (
  input  logic [7:0]        did,
  input  logic [7:0]        sdid,
  input  logic [8*NENT-1:0] t_did,
  input  logic [8*NENT-1:0] t_sdid,
  input  logic [NENT-1:0]   t_chk,
  input  logic [NENT-1:0]   t_vld,
  output logic              hit
);
  logic [NENT-1:0] ent_hit;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    assign ent_hit[e] = t_vld[e] && (t_did[8*e +: 8] == did) &&
                        (!t_chk[e] || (t_sdid[8*e +: 8] == sdid));
  end

  assign hit = (t_vld == '0) || (ent_hit != '0);
endmodule

// File: rtl/anc_pkt_parser.sv
module anc_pkt_parser
  import anc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          del_en,
  input  logic          v,
  input  logic [WW-1:0] w,
  input  logic          hit,
  output logic [7:0]    did_q,
  output logic          new_blank,
  output logic          retro
);
  pstate_t       st;
  logic [WW-1:0] h1, h2;
  logic [1:0]    seen;
  logic [8:0]    rem;
  logic          del_q;
  logic          flag_det;

  assign flag_det = (seen == 2'b11) && (h2 == FLAG0) && (h1 == FLAG1) && (w == FLAG1);

  always_comb begin
    retro     = 1'b0;
    new_blank = 1'b0;
    if (en && v) begin
      case (st)
        PS_SDID: begin
          retro     = del_en && hit;
          new_blank = del_en && hit;
        end
        PS_COUNT, PS_BODY: new_blank = del_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st    <= PS_SEARCH;
      seen  <= 2'b00;
      h1    <= '0;
      h2    <= '0;
      rem   <= '0;
      del_q <= 1'b0;
      did_q <= '0;
    end else if (v) begin
      case (st)
        PS_SEARCH: begin
          if (flag_det) begin
            st   <= PS_DID;
            seen <= 2'b00;
          end else begin
            h2   <= h1;
            h1   <= w;
            seen <= {seen[0], 1'b1};
          end
        end
        PS_DID: begin
          did_q <= w[7:0];
          st    <= PS_SDID;
        end
        PS_SDID: begin
          del_q <= del_en && hit;
          st    <= PS_COUNT;
        end
        PS_COUNT: begin
          rem <= {1'b0, w[7:0]} + 9'd1;
          st  <= PS_BODY;
        end
        PS_BODY: begin
          rem <= rem - 9'd1;
          if (rem == 9'd1) st <= PS_SEARCH;
        end
        default: st <= PS_SEARCH;
      endcase
    end
  end

  assert_no_mark_off_R1: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!new_blank && !retro));
  assert_retro_needs_del_R2: assert property (@(posedge clk) disable iff (rst)
    retro |-> del_en);
  assert_retro_then_count_R7: assert property (@(posedge clk) disable iff (rst)
    retro |=> (st == PS_COUNT));
  assert_rem_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    rem <= 9'd256);
endmodule

// File: rtl/anc_delay_line.sv
module anc_delay_line
  import anc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift,
  input  logic [WW-1:0] din,
  input  logic          cin,
  input  logic          bin,
  input  logic          retro,
  output logic [WW-1:0] dout,
  output logic          cout,
  output logic          bout,
  output logic          full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WW-1:0] wd [DEPTH];
  logic [DEPTH-1:0] ch, bk;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (shift) begin
      wd[0] <= din;
      for (int i = 1; i < DEPTH; i++) wd[i] <= wd[i-1];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_tag
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          ch[0] <= 1'b0;
          bk[0] <= 1'b0;
        end else if (shift) begin
          ch[0] <= cin;
          bk[0] <= bin;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          ch[i] <= 1'b0;
          bk[i] <= 1'b0;
        end else if (shift) begin
          ch[i] <= ch[i-1];
          bk[i] <= bk[i-1] | (retro && (i <= HDR_BACK));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (shift && (cnt != CW'(DEPTH))) cnt <= cnt + 1'b1;
  end

  assign dout = wd[DEPTH-1];
  assign cout = ch[DEPTH-1];
  assign bout = bk[DEPTH-1];
  assign full = (cnt == CW'(DEPTH));

  assert_full_sticks_R6: assert property (@(posedge clk) disable iff (rst)
    full |=> full);
endmodule

// File: rtl/anc_blank_filter.sv
module anc_blank_filter
  import anc_pkg::*;
#(
  parameter int NENT  = 4,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [9:0]        in_word,
  input  logic              in_valid,
  input  logic              in_chroma,
  input  logic              proc_en,
  input  logic              del_en,
  input  logic [8*NENT-1:0] flt_did,
  input  logic [8*NENT-1:0] flt_sdid,
  input  logic [NENT-1:0]   flt_sdid_chk,
  input  logic [NENT-1:0]   flt_vld,
  output logic [9:0]        out_word,
  output logic              out_valid
);
  logic [7:0]    did_q;
  logic          hit, new_blank, retro;
  logic [WW-1:0] dl_word;
  logic          dl_chroma, dl_blank, dl_full;
  logic          out_blk_q;

  anc_id_match #(.NENT(NENT)) u_match (
    .did(did_q), .sdid(in_word[7:0]),
    .t_did(flt_did), .t_sdid(flt_sdid), .t_chk(flt_sdid_chk), .t_vld(flt_vld),
    .hit(hit)
  );

  anc_pkt_parser u_parse (
    .clk(clk), .rst(rst), .en(proc_en), .del_en(del_en),
    .v(in_valid), .w(in_word), .hit(hit),
    .did_q(did_q), .new_blank(new_blank), .retro(retro)
  );

  anc_delay_line #(.DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst(rst), .shift(in_valid),
    .din(in_word), .cin(in_chroma), .bin(new_blank), .retro(retro),
    .dout(dl_word), .cout(dl_chroma), .bout(dl_blank), .full(dl_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word  <= '0;
      out_valid <= 1'b0;
      out_blk_q <= 1'b0;
    end else if (in_valid) begin
      out_valid <= dl_full;
      out_blk_q <= proc_en && dl_blank;
      out_word  <= (proc_en && dl_blank) ? blank_of(dl_chroma) : dl_word;
    end else begin
      out_valid <= 1'b0;
    end
  end

  assert_blank_value_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_blk_q) |-> ((out_word == BLANK_C) || (out_word == BLANK_Y)));
  assert_empty_table_hits_R4: assert property (@(posedge clk) disable iff (rst)
    (flt_vld == '0) |-> hit);
  assert_out_follows_in_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
endmodule

// File: tb/tb_anc_blank_filter.sv
module tb_anc_blank_filter;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int NENT  = 4;
  localparam int MAXW  = 512;

  logic clk = 1'b0, rst = 1'b1;
  logic [9:0] in_word = '0;
  logic in_valid = 1'b0, in_chroma = 1'b0, proc_en = 1'b1, del_en = 1'b1;
  logic [7:0] t_did [NENT], t_sdid [NENT];
  logic [NENT-1:0] t_chk = '0, t_vld = '0;
  logic [8*NENT-1:0] flt_did, flt_sdid;
  logic [9:0] out_word;
  logic out_valid;

  int checks = 0, fails = 0;
  logic [9:0] sw [MAXW];
  logic       sc [MAXW];
  logic [9:0] ex [MAXW];
  logic [9:0] cap [MAXW];
  int n = 0, ncap = 0;
  bit capturing = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int e = 0; e < NENT; e++) begin
      flt_did[8*e +: 8]  = t_did[e];
      flt_sdid[8*e +: 8] = t_sdid[e];
    end
  end

  anc_blank_filter #(.NENT(NENT), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
    .in_chroma(in_chroma), .proc_en(proc_en), .del_en(del_en),
    .flt_did(flt_did), .flt_sdid(flt_sdid), .flt_sdid_chk(t_chk), .flt_vld(t_vld),
    .out_word(out_word), .out_valid(out_valid)
  );

  always @(negedge clk) begin
    if (capturing && out_valid && ncap < MAXW) begin
      cap[ncap] = out_word;
      ncap++;
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  task automatic chk(string req, logic [9:0] act, logic [9:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%03h expected 0x%03h", req, what, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int e = 0; e < NENT; e++) begin t_did[e] = '0; t_sdid[e] = '0; end
    t_chk = '0; t_vld = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put(logic [9:0] w);
    sw[n] = w; sc[n] = n[0]; n++;
  endtask

  task automatic put_fill(int k);
    for (int i = 0; i < k; i++) put(10'h100 + 10'((n * 7) % 200));
  endtask

  task automatic put_pkt(logic [7:0] did, logic [7:0] sdid, int dc);
    put(10'h000); put(10'h3FF); put(10'h3FF);
    put({2'b10, did}); put({2'b01, sdid}); put({2'b10, 8'(dc)});
    for (int i = 0; i < dc; i++) put(10'h080 + 10'(i * 3));
    put(10'h155);
  endtask

  function automatic bit tbl_match(logic [7:0] did, logic [7:0] sdid);
    bit any_v = 0, any_h = 0;
    for (int e = 0; e < NENT; e++) begin
      if (t_vld[e]) begin
        any_v = 1;
        if (t_did[e] == did && (!t_chk[e] || t_sdid[e] == sdid)) any_h = 1;
      end
    end
    return !any_v || any_h;
  endfunction

  task automatic model();
    int i = 0;
    for (int j = 0; j < n; j++) ex[j] = sw[j];
    while (i + 5 < n) begin
      if (sw[i] == 10'h000 && sw[i+1] == 10'h3FF && sw[i+2] == 10'h3FF) begin
        int len = 7 + int'(sw[i+5][7:0]);
        if (proc_en && del_en && tbl_match(sw[i+3][7:0], sw[i+4][7:0]))
          for (int j = i; j < i + len && j < n; j++) ex[j] = sc[j] ? 10'h200 : 10'h040;
        i += len;
      end else i++;
    end
  endtask

  task automatic run(string req, bit gaps);
    model();
    do_reset();
    ncap = 0; capturing = 1;
    for (int i = 0; i < n + DEPTH; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid  = 1'b1;
      in_word   = (i < n) ? sw[i] : 10'h040;
      in_chroma = (i < n) ? sc[i] : 1'b0;
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    capturing = 0;
    chk("R6", 10'(ncap), 10'(n), "output word count");
    for (int k = 0; k < n && k < ncap; k++)
      chk(req, cap[k], ex[k], $sformatf("word %0d", k));
    n = 0;
  endtask

  task automatic t_reset_latency();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R9", {9'd0, out_valid}, 10'd0, "out_valid in reset");
    chk("R9", out_word, 10'd0, "out_word in reset");
    rst = 1'b0;
    for (int i = 0; i <= DEPTH; i++) begin
      @(negedge clk);
      if (i > 0) chk("R9", {9'd0, out_valid}, 10'd0, $sformatf("out_valid after input %0d", i));
      in_valid = 1'b1; in_word = 10'h1A0 + 10'(i); in_chroma = 1'b0;
    end
    @(negedge clk); in_valid = 1'b0;
    chk("R6", {9'd0, out_valid}, 10'd1, "out_valid after input DEPTH+1");
    chk("R6", out_word, 10'h1A0, "first word out");
  endtask

  task automatic t_all_delete();
    clear_tbl(); proc_en = 1; del_en = 1;
    put_fill(5); put_pkt(8'h41, 8'h01, 3); put_fill(4); put_pkt(8'h60, 8'h22, 0); put_fill(6);
    run("R4 R7 R3", 0);
  endtask

  task automatic t_del_off();
    clear_tbl(); proc_en = 1; del_en = 0;
    put_fill(3); put_pkt(8'h41, 8'h01, 4); put_fill(5);
    run("R2", 0);
  endtask

  task automatic t_proc_off();
    clear_tbl(); proc_en = 0; del_en = 1;
    put_fill(3); put_pkt(8'h41, 8'h01, 2); put_fill(5);
    run("R1", 0);
  endtask

  task automatic t_did_only();
    clear_tbl(); proc_en = 1; del_en = 1;
    t_did[2] = 8'h41; t_vld[2] = 1'b1;
    put_fill(2); put_pkt(8'h41, 8'h01, 2); put_pkt(8'h60, 8'h01, 2);
    put_pkt(8'h41, 8'h07, 1); put_fill(4);
    run("R5 R8", 0);
  endtask

  task automatic t_did_sdid();
    clear_tbl(); proc_en = 1; del_en = 1;
    t_did[0] = 8'h61; t_sdid[0] = 8'h02; t_chk[0] = 1'b1; t_vld[0] = 1'b1;
    t_did[3] = 8'h50; t_vld[3] = 1'b1;
    put_fill(3); put_pkt(8'h61, 8'h01, 3); put_fill(2); put_pkt(8'h61, 8'h02, 5);
    put_pkt(8'h50, 8'hAA, 0); put_fill(5);
    run("R5 R3", 0);
  endtask

  task automatic t_gaps();
    clear_tbl(); proc_en = 1; del_en = 1;
    put_fill(4); put_pkt(8'h41, 8'h05, 6); put_pkt(8'h42, 8'h06, 1); put_fill(7);
    run("R6 R8", 1);
  endtask

  initial begin
    clear_tbl();
    t_reset_latency();
    t_all_delete();
    t_del_off();
    t_proc_off();
    t_did_only();
    t_did_sdid();
    t_gaps();
    report();
  end
endmodule